// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns an asynchronous serial line into received characters. It is clocked by the system clock and advances its bit timing only on cycles where an oversample strobe is high; that strobe runs at sixteen times the bit rate. A falling edge on the idle-high line opens a candidate start bit. The candidate is confirmed at its centre, and then every following bit is sampled once, at its centre.

The frame layout comes from an eight-bit line-control byte. The transmitter of the same port uses this byte too. Its fields select the character width (5 to 8 bits), parity on or off, even or odd parity, and stick parity. The receiver latches these fields when a start bit is confirmed, so changing the byte mid-frame does not disturb the frame in progress. When the stop bit has been sampled, the block presents the character right-aligned and zero-extended. It also pulses a valid strobe and reports parity, framing and break conditions for that character.

Top module: `serial_rx_core`

## Requirements
- R1: The character width is 5 + `line_ctrl[1:0]` bits (00→5, 01→6, 10→7, 11→8). Data bits arrive least significant first. `rx_byte` holds them right-aligned, with every bit above the width cleared.
- R2: A start bit is accepted only after a high-to-low transition of the line, and only if the line still reads low on the 8th oversample tick counted from the tick that saw the transition. A shorter low pulse produces no character.
- R3: When `line_ctrl[3]` is 0, no parity bit is expected. The bit after the last data bit is taken as the stop bit, and `parity_err` stays 0.
- R4: When `line_ctrl[3]` is 1 and `line_ctrl[5]` is 0, the parity bit follows the last data bit. `parity_err` is set unless the count of ones over the data and parity bits is even (`line_ctrl[4]`=1) or odd (`line_ctrl[4]`=0).
- R5: When `line_ctrl[3]` and `line_ctrl[5]` are both 1, the parity bit must be 0 if `line_ctrl[4]` is 1 and must be 1 if `line_ctrl[4]` is 0. Any other value sets `parity_err`.
- R6: Only the first stop bit is sampled. `framing_err` is set when it reads 0, and no further stop bits are required before the next start bit, whatever `line_ctrl[2]` says.
- R7: `break_seen` is set when every data bit, the parity bit (when enabled) and the first stop bit all sample as 0. A held-low line yields exactly one character until the line returns high.
- R8: After the stop-bit sample the receiver hunts for a new start edge at once, so characters sent back to back are all received.
- R9: `line_ctrl[7]`, `line_ctrl[6]` (transmit break) and `line_ctrl[2]` (stop-bit count) have no effect on what is received.
- R10: `rx_strobe` is high for exactly one clock per character. `rx_byte` and the three flags update in that same cycle and hold until the next character.
- R11: After synchronous reset, `rx_strobe`, `rx_byte` and all flags are 0.
- R12: The frame fields of `line_ctrl` are captured when the start bit is confirmed. Changes made during the frame do not alter its reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversample strobe, 16 per bit period |
| rxd_in | input | 1 | Asynchronous serial input, idle high |
| line_ctrl | input | 8 | Line-control byte shared with the transmitter |
| rx_byte | output | 8 | Received character, zero-extended |
| rx_strobe | output | 1 | One-cycle pulse when a character is ready |
| parity_err | output | 1 | Parity mismatch for the presented character |
| framing_err | output | 1 | First stop bit read as 0 |
| break_seen | output | 1 | Whole frame read as 0 |

## Verification
A wrong internal state shows up as a wrong character. A bit counter that is off shifts or truncates `rx_byte`, or leaves stray high bits above the width. A phase error in the oversample counter moves the sampling point onto a bit edge. These faults appear at the strobe of the very first character, about ten bit periods after the start edge. Wrong state in the hunt logic shows up in one of two ways: a glitch produces a strobe, or the next back-to-back character is lost and fails to strobe within one frame time. Parity and stick-parity faults change only the flags. They are exposed by sending each frame both with a correct parity bit and with a flipped one.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int OVERSAMPLE = 16;
    localparam int MID_TICK   = OVERSAMPLE / 2;
    localparam int CTR_W      = $clog2(OVERSAMPLE);
    localparam int DATA_W     = 8;
    localparam int IDX_W      = $clog2(DATA_W);

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_t;

    typedef struct packed {
        logic       stick;
        logic       even;
        logic       par_on;
        logic [1:0] wsel;
    } rx_cfg_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              par_bit;
        logic              stop_bit;
        rx_cfg_t           cfg;
    } rx_frame_t;

    typedef struct packed {
        logic par_err;
        logic frm_err;
        logic brk;
    } rx_flags_t;

    function automatic rx_cfg_t decode_cfg(input logic [4:0] c);
        rx_cfg_t r;
        r.wsel   = c[1:0];
        r.par_on = c[3];
        r.even   = c[4];
        r.stick  = c[2];
        return r;
    endfunction

    function automatic logic [3:0] width_of(input logic [1:0] w);
        return 4'd5 + {2'b00, w};
    endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer
    import serial_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      line,
    input  logic [4:0] ctrl,
    output logic      done,
    output rx_frame_t frame
);
    rx_state_t        state;
    logic [CTR_W-1:0] ctr;
    logic [IDX_W-1:0] idx;
    logic             prev;
    logic [3:0]       nbits;
    logic             mid;

    assign nbits = width_of(frame.cfg.wsel);
    assign mid   = (ctr == CTR_W'(OVERSAMPLE - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HUNT;
            ctr   <= '0;
            idx   <= '0;
            prev  <= 1'b1;
            done  <= 1'b0;
            frame <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                prev <= line;
                case (state)
                    ST_HUNT: begin
                        if (prev && !line) begin
                            state <= ST_START;
                            ctr   <= CTR_W'(1);
                        end
                    end
                    ST_START: begin
                        if (ctr == CTR_W'(MID_TICK - 1)) begin
                            ctr <= '0;
                            if (!line) begin
                                state          <= ST_DATA;
                                idx            <= '0;
                                frame.data     <= '0;
                                frame.par_bit  <= 1'b0;
                                frame.cfg      <= decode_cfg(ctrl);
                            end else begin
                                state <= ST_HUNT;
                            end
                        end else begin
                            ctr <= ctr + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        ctr <= ctr + 1'b1;
                        if (mid) begin
                            frame.data[idx] <= line;
                            if ({1'b0, idx} == nbits - 4'd1)
                                state <= frame.cfg.par_on ? ST_PAR : ST_STOP;
                            else
                                idx <= idx + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        ctr <= ctr + 1'b1;
                        if (mid) begin
                            frame.par_bit <= line;
                            state         <= ST_STOP;
                        end
                    end
                    ST_STOP: begin
                        ctr <= ctr + 1'b1;
                        if (mid) begin
                            frame.stop_bit <= line;
                            done           <= 1'b1;
                            state          <= ST_HUNT;
                        end
                    end
                    default: state <= ST_HUNT;
                endcase
            end
        end
    end

    assert_zero_ext_R1: assert property (@(posedge clk) disable iff (rst)
        done |-> ((frame.data >> nbits) == '0));

    assert_idx_bound_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA) |-> ({1'b0, idx} < nbits));

    assert_done_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(tick));

    assert_start_from_hunt_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && $past(state) != ST_DATA) |-> $past(state) == ST_START);
endmodule

// File: rtl/serial_rx_check.sv
module serial_rx_check
    import serial_rx_pkg::*;
(
    input  rx_frame_t frame,
    output rx_flags_t flags
);
    logic ones_odd;
    logic normal_bad;
    logic stick_bad;

    always_comb begin
        ones_odd      = (^frame.data) ^ frame.par_bit;
        normal_bad    = frame.cfg.even ? ones_odd : ~ones_odd;
        stick_bad     = (frame.par_bit == frame.cfg.even);
        flags.par_err = frame.cfg.par_on & (frame.cfg.stick ? stick_bad : normal_bad);
        flags.frm_err = ~frame.stop_bit;
        flags.brk     = (frame.data == '0) & ~frame.par_bit & ~frame.stop_bit;
    end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import serial_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              os_tick,
    input  logic              rxd_in,
    input  logic [7:0]        line_ctrl,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_strobe,
    output logic              parity_err,
    output logic              framing_err,
    output logic              break_seen
);
    logic      line_s;
    logic      done;
    rx_frame_t frame;
    rx_flags_t flags;
    logic      ctrl_unused;
    logic [4:0] ctrl_fields;

    assign ctrl_unused = ^{line_ctrl[7:6], line_ctrl[2]};
    // stick select sits at bit 5; packed into slot 2 for the decoder
    assign ctrl_fields = {line_ctrl[4:3], line_ctrl[5], line_ctrl[1:0]};

    serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (rxd_in),
        .dout(line_s)
    );

    serial_rx_framer u_framer (
        .clk  (clk),
        .rst  (rst),
        .tick (os_tick),
        .line (line_s),
        .ctrl (ctrl_fields),
        .done (done),
        .frame(frame)
    );

    serial_rx_check u_check (
        .frame(frame),
        .flags(flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_byte     <= '0;
            rx_strobe   <= 1'b0;
            parity_err  <= 1'b0;
            framing_err <= 1'b0;
            break_seen  <= 1'b0;
        end else begin
            rx_strobe <= done;
            if (done) begin
                rx_byte     <= frame.data;
                parity_err  <= flags.par_err;
                framing_err <= flags.frm_err;
                break_seen  <= flags.brk;
            end
        end
    end

    assert_strobe_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        rx_strobe |=> !rx_strobe);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !rx_strobe |-> $stable(rx_byte) && $stable(break_seen));

    assert_break_frame_R7: assert property (@(posedge clk) disable iff (rst)
        break_seen |-> framing_err && (rx_byte == '0));
endmodule

// File: tb/serial_rx_core_tb.sv
module serial_rx_core_tb;
    localparam int BIT_CLKS = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick = 1'b0;
    logic       rxd_in = 1'b1;
    logic [7:0] line_ctrl = 8'h03;
    logic [7:0] rx_byte;
    logic       rx_strobe, parity_err, framing_err, break_seen;

    int checks = 0;
    int errors = 0;
    int frames_seen = 0;
    logic [7:0] cap_data [0:63];
    logic       cap_pe   [0:63];
    logic       cap_fe   [0:63];
    logic       cap_bk   [0:63];
    logic       prev_strobe = 1'b0;
    logic       finished = 1'b0;

    always #2 clk = ~clk;

    always @(posedge clk) os_tick <= rst ? 1'b0 : ~os_tick;

    serial_rx_core u_dut (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rxd_in(rxd_in),
        .line_ctrl(line_ctrl), .rx_byte(rx_byte), .rx_strobe(rx_strobe),
        .parity_err(parity_err), .framing_err(framing_err), .break_seen(break_seen)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_strobe && prev_strobe)
                chk(1'b0, "R10", "strobe longer than one cycle", 2, 1);
            if (rx_strobe && frames_seen < 64) begin
                cap_data[frames_seen] = rx_byte;
                cap_pe[frames_seen]   = parity_err;
                cap_fe[frames_seen]   = framing_err;
                cap_bk[frames_seen]   = break_seen;
            end
            if (rx_strobe) frames_seen++;
        end
        prev_strobe = rx_strobe;
    end

    function automatic logic par_for(input logic [7:0] d, input logic [7:0] c);
        logic [7:0] m;
        m = d & ((8'd1 << (5 + c[1:0])) - 8'd1);
        if (c[5]) return ~c[4];
        return c[4] ? ^m : ~^m;
    endfunction

    task automatic drive_bit(input logic v);
        rxd_in = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic [7:0] c, input logic flip,
                        input logic stop_v, input int nstop);
        int n;
        n = 5 + c[1:0];
        line_ctrl = c;
        drive_bit(1'b0);
        for (int i = 0; i < n; i++) drive_bit(d[i]);
        if (c[3]) drive_bit(par_for(d, c) ^ flip);
        drive_bit(stop_v);
        for (int i = 1; i < nstop; i++) drive_bit(1'b1);
        rxd_in = 1'b1;
    endtask

    task automatic idle(input int bits);
        rxd_in = 1'b1;
        repeat (bits * BIT_CLKS) @(negedge clk);
    endtask

    task automatic expect_one(input string req, input int base, input logic [7:0] ed,
                              input logic epe, input logic efe, input logic ebk);
        chk(frames_seen == base + 1, req, "frame count", frames_seen - base, 1);
        if (frames_seen > base) begin
            chk(cap_data[base] == ed, req, "data", cap_data[base], ed);
            chk(cap_pe[base] == epe, req, "parity_err", cap_pe[base], epe);
            chk(cap_fe[base] == efe, req, "framing_err", cap_fe[base], efe);
            chk(cap_bk[base] == ebk, req, "break_seen", cap_bk[base], ebk);
        end
    endtask

    task automatic t_reset_r11();
        chk(rx_strobe == 0 && rx_byte == 0 && parity_err == 0 && framing_err == 0
            && break_seen == 0, "R11", "reset outputs",
            {rx_strobe, parity_err, framing_err, break_seen, rx_byte}, 0);
    endtask

    task automatic t_widths_r1_r3();
        for (int w = 0; w < 4; w++) begin
            int base;
            logic [7:0] m;
            base = frames_seen;
            m = 8'hB5 & ((8'd1 << (5 + w)) - 8'd1);
            send(8'hB5, {6'b0, 2'(w)}, 1'b0, 1'b1, 1);
            idle(2);
            expect_one("R1_R3", base, m, 1'b0, 1'b0, 1'b0);
        end
    endtask

    task automatic t_parity_r4();
        logic [7:0] cfgs [4] = '{8'h1B, 8'h0B, 8'h1A, 8'h0A};
        for (int k = 0; k < 4; k++) begin
            for (int f = 0; f < 2; f++) begin
                int base;
                base = frames_seen;
                send(8'h6D, cfgs[k], f[0], 1'b1, 1);
                idle(2);
                expect_one("R4", base, cfgs[k][0] ? 8'h6D : 8'h6D & 8'h7F,
                           f[0], 1'b0, 1'b0);
            end
        end
    endtask

    task automatic t_stick_r5();
        // stick even: parity bit must be 0 ; stick odd: must be 1
        logic [7:0] cfgs [2] = '{8'h3B, 8'h2B};
        for (int k = 0; k < 2; k++) begin
            for (int pv = 0; pv < 2; pv++) begin
                int base;
                logic exp_pe;
                base = frames_seen;
                exp_pe = (pv[0] != ~cfgs[k][4]);
                send(8'h81, cfgs[k], pv[0] ^ par_for(8'h81, cfgs[k]), 1'b1, 1);
                idle(2);
                expect_one("R5", base, 8'h81, exp_pe, 1'b0, 1'b0);
            end
        end
    endtask

    task automatic t_stop_r6();
        int base;
        base = frames_seen;
        send(8'h3C, 8'h03, 1'b0, 1'b0, 1);
        idle(2);
        expect_one("R6", base, 8'h3C, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_back_to_back_r8_r6();
        int base;
        base = frames_seen;
        send(8'h11, 8'h07, 1'b0, 1'b1, 1);
        send(8'hEE, 8'h07, 1'b0, 1'b1, 1);
        send(8'h5A, 8'h07, 1'b0, 1'b1, 1);
        idle(2);
        chk(frames_seen == base + 3, "R8", "back-to-back count", frames_seen - base, 3);
        if (frames_seen >= base + 3) begin
            chk(cap_data[base] == 8'h11, "R8", "first", cap_data[base], 8'h11);
            chk(cap_data[base+1] == 8'hEE, "R6", "second", cap_data[base+1], 8'hEE);
            chk(cap_data[base+2] == 8'h5A, "R8", "third", cap_data[base+2], 8'h5A);
            chk(cap_fe[base+1] == 1'b0, "R6", "no fe w/ one stop", cap_fe[base+1], 0);
        end
    endtask

    task automatic t_break_r7();
        int base;
        base = frames_seen;
        line_ctrl = 8'h1B;
        drive_bit(1'b0);
        repeat (14) drive_bit(1'b0);
        idle(3);
        expect_one("R7", base, 8'h00, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_glitch_r2();
        int base;
        base = frames_seen;
        rxd_in = 1'b0;
        repeat (6) @(negedge clk);
        idle(12);
        chk(frames_seen == base, "R2", "glitch ignored", frames_seen - base, 0);
        rxd_in = 1'b0;
        repeat (12) @(negedge clk);
        idle(12);
        chk(frames_seen == base, "R2", "short low ignored", frames_seen - base, 0);
    endtask

    task automatic t_ignored_r9();
        int base;
        base = frames_seen;
        send(8'hA7, 8'hC7, 1'b0, 1'b1, 2);
        idle(2);
        expect_one("R9", base, 8'hA7, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_latch_r12();
        int base;
        base = frames_seen;
        fork
            send(8'hC3, 8'h03, 1'b0, 1'b1, 1);
            begin
                repeat (2 * BIT_CLKS) @(negedge clk);
                line_ctrl = 8'h0A;
            end
        join
        idle(2);
        expect_one("R12", base, 8'hC3, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_hold_r10();
        logic [7:0] last;
        last = rx_byte;
        idle(4);
        chk(rx_byte == last && rx_strobe == 0, "R10", "hold between frames", rx_byte, last);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        idle(1);
        t_reset_r11();
        t_widths_r1_r3();
        t_parity_r4();
        t_stick_r5();
        t_stop_r6();
        t_back_to_back_r8_r6();
        t_break_r7();
        t_glitch_r2();
        t_ignored_r9();
        t_latch_r12();
        t_hold_r10();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule